// File: doc/BRIEF.md
# Virtual-Channel Binding Table Keyed by Packet Source

This block sits at one input port of a mesh router in which a flit may cross several routers in one cycle and stops wherever the path set up for it ends. Because the upstream sender cannot know where its flit will stop, it cannot choose the virtual channel (VC) there. Instead, each input port keeps this table. A head flit that stops here, or only passes through, claims the lowest-numbered free VC of its virtual network. The table records which injection (source) router the VC now belongs to. Body and tail flits of the same packet later find their VC by presenting that source ID.

A tail removes the source binding when it arrives. If the tail stops here, the VC stays held until its buffer has drained, and the buffer side reports that with a release event. If the tail passes through, the VC is released at once. One output bit per virtual network tells the upstream neighbour whether at least one VC of that network is free. The flit channel has no ready signal: the neighbour only sends when that bit is high. Every flit event is therefore taken in the cycle it is presented.

Results are registered: each flit event yields a result one clock later.

Top module: `vcmap_table`

## Requirements
- R1: After reset every VC is free: `vc_avail` is all ones, and `res_valid`, `res_hit`, `err_miss` and `err_full` are 0.
- R2: A head flit (`fl_type`=2'b00) in virtual network v takes the lowest-numbered free VC of that network. The VCs of network v have global indices v*VC_PER_VNET to v*VC_PER_VNET+VC_PER_VNET-1. One cycle later the block shows `res_valid`=1, `res_hit`=1 and `res_vc`=that index.
- R3: A body (2'b01) or tail (2'b10) flit returns, one cycle later with `res_hit`=1, the VC currently bound to the same source ID in the same network.
- R4: A body or tail flit whose ID has no binding in its network gives `res_hit`=0 and a one-cycle `err_miss` pulse, and changes no state.
- R5: A head flit whose network has no free VC gives `res_hit`=0 and a one-cycle `err_full` pulse, and changes no state.
- R6: A tail with `fl_stop`=1 removes the binding, so a later body or tail with that ID misses. The VC itself stays held.
- R7: A `dep_valid` event with `dep_vc` naming a held, drained-pending VC frees it from the next cycle. A head in the same cycle sees the VC as not yet free. A release naming a VC that is free or still bound is ignored.
- R8: A tail with `fl_stop`=0 (passing through) removes the binding and frees the VC in the same step.
- R9: A single-flit packet (2'b11) is reported like a head, on the lowest free VC. With `fl_stop`=1 the VC becomes held, pending release. With `fl_stop`=0 no VC stays held.
- R10: `vc_avail[v]` is 1 exactly when at least one VC of network v is free, following the state left by the last clock edge.
- R11: Bindings are per network: the same source ID may be bound in two networks at once, and each lookup only searches its own network's VCs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_valid | input | 1 | A flit arrives or passes this cycle |
| fl_type | input | 2 | 00 head, 01 body, 10 tail, 11 single-flit |
| fl_stop | input | 1 | 1 when the flit is buffered here, 0 when it passes through |
| fl_vnet | input | idx_w(NUM_VNET) | Virtual network of the flit |
| fl_src | input | ID_W | Injection router ID of the packet |
| dep_valid | input | 1 | A buffered tail has left its VC |
| dep_vc | input | idx_w(NUM_VC) | VC the tail left |
| res_valid | output | 1 | Result for the previous cycle's flit |
| res_hit | output | 1 | Allocation or lookup succeeded |
| res_vc | output | idx_w(NUM_VC) | Global VC index of the result |
| err_miss | output | 1 | Body/tail found no binding |
| err_full | output | 1 | Head/single found no free VC |
| vc_avail | output | NUM_VNET | Per network: at least one VC free |

## Verification
The hardest situations to reach are the same-cycle collisions. In one, a release frees a VC just as a head in that network finds every VC occupied. In another, a passing tail frees a VC that the very next head must take. Reaching them requires filling a network to its last VC while one VC sits in the held, drained-pending state. The directed sequence builds that fill on purpose and then issues the release and the head together. A constrained pseudo-random phase follows, against the behavioural model, to mix passing and stopping tails across both networks.

// File: rtl/vcmap_pkg.sv
package vcmap_pkg;
  typedef enum logic [1:0] {
    FT_HEAD   = 2'b00,
    FT_BODY   = 2'b01,
    FT_TAIL   = 2'b10,
    FT_SINGLE = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    VC_FREE  = 2'b00,
    VC_BOUND = 2'b01,
    VC_DRAIN = 2'b10
  } vc_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vcmap_entry.sv
module vcmap_entry
  import vcmap_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_i,
  input  logic [1:0]      kind_i,
  input  logic            stop_i,
  input  logic            tail_i,
  input  logic            dep_i,
  input  logic [ID_W-1:0] src_i,
  output vc_state_e       state_o,
  output logic [ID_W-1:0] src_o
);
  vc_state_e       st_q, st_d;
  logic [ID_W-1:0] src_q, src_d;

  always_comb begin
    st_d  = st_q;
    src_d = src_q;
    unique case (st_q)
      VC_FREE: if (alloc_i) begin
        if (kind_i == FT_HEAD) begin
          st_d  = VC_BOUND;
          src_d = src_i;
        end else if (stop_i) begin
          st_d = VC_DRAIN;
        end
      end
      VC_BOUND: if (tail_i) st_d = stop_i ? VC_DRAIN : VC_FREE;
      VC_DRAIN: if (dep_i) st_d = VC_FREE;
      default:  st_d = VC_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= VC_FREE;
      src_q <= '0;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
    end
  end

  assign state_o = st_q;
  assign src_o   = src_q;

  // a free VC leaves that state only through allocation (R2)
  assert_free_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == VC_FREE && !alloc_i) |=> (st_q == VC_FREE));

  // a held VC waits for its release event (R7)
  assert_drain_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == VC_DRAIN && !dep_i) |=> (st_q == VC_DRAIN));

  // a binding keeps its source ID until a tail removes it (R6)
  assert_binding_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == VC_BOUND && !tail_i) |=> (st_q == VC_BOUND && $stable(src_q)));
endmodule

// File: rtl/vcmap_alloc.sv
module vcmap_alloc #(
  parameter int NUM_VNET    = 2,
  parameter int VC_PER_VNET = 2,
  localparam int NUM_VC     = NUM_VNET * VC_PER_VNET,
  localparam int VN_W       = vcmap_pkg::idx_w(NUM_VNET)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] free_i,
  input  logic [VN_W-1:0]   vnet_i,
  output logic [NUM_VC-1:0] gnt_o
);
  for (genvar v = 0; v < NUM_VNET; v++) begin : g_net
    logic [VC_PER_VNET-1:0] slice, pick;
    assign slice = free_i[v*VC_PER_VNET +: VC_PER_VNET];

    always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < VC_PER_VNET; k++) begin
        if (slice[k] && !found) begin
          pick[k] = 1'b1;
          found   = 1'b1;
        end
      end
    end

    assign gnt_o[v*VC_PER_VNET +: VC_PER_VNET] =
      (vnet_i == VN_W'(v)) ? pick : '0;
  end

  // at most one VC granted, and only a free one (R2)
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && ((gnt_o & ~free_i) == '0));
endmodule

// File: rtl/vcmap_match.sv
module vcmap_match
  import vcmap_pkg::*;
#(
  parameter int NUM_VNET    = 2,
  parameter int VC_PER_VNET = 2,
  parameter int ID_W        = 6,
  localparam int NUM_VC     = NUM_VNET * VC_PER_VNET,
  localparam int VN_W       = idx_w(NUM_VNET)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   look_i,
  input  logic [NUM_VC-1:0]      bound_i,
  input  logic [NUM_VC*ID_W-1:0] src_tab_i,
  input  logic [VN_W-1:0]        vnet_i,
  input  logic [ID_W-1:0]        src_i,
  output logic [NUM_VC-1:0]      hit_o
);
  for (genvar i = 0; i < NUM_VC; i++) begin : g_cmp
    localparam int NET = i / VC_PER_VNET;
    assign hit_o[i] = bound_i[i]
                    && (vnet_i == VN_W'(NET))
                    && (src_tab_i[i*ID_W +: ID_W] == src_i);
  end

  // one live binding per source ID and network (R3, R11)
  assert_unique_bind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    look_i |-> ($countones(hit_o) <= 1));
endmodule

// File: rtl/vcmap_table.sv
module vcmap_table
  import vcmap_pkg::*;
#(
  parameter int NUM_VNET    = 2,
  parameter int VC_PER_VNET = 2,
  parameter int ID_W        = 6
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    fl_valid,
  input  logic [1:0]                              fl_type,
  input  logic                                    fl_stop,
  input  logic [idx_w(NUM_VNET)-1:0]              fl_vnet,
  input  logic [ID_W-1:0]                         fl_src,
  input  logic                                    dep_valid,
  input  logic [idx_w(NUM_VNET*VC_PER_VNET)-1:0]  dep_vc,
  output logic                                    res_valid,
  output logic                                    res_hit,
  output logic [idx_w(NUM_VNET*VC_PER_VNET)-1:0]  res_vc,
  output logic                                    err_miss,
  output logic                                    err_full,
  output logic [NUM_VNET-1:0]                     vc_avail
);
  localparam int NUM_VC = NUM_VNET * VC_PER_VNET;
  localparam int VC_W   = idx_w(NUM_VC);

  vc_state_e             st   [NUM_VC];
  logic [NUM_VC-1:0]     free_vec, bound_vec, drain_vec;
  logic [NUM_VC*ID_W-1:0] src_tab;
  logic [NUM_VC-1:0]     gnt, match, sel;
  logic                  is_alloc, is_look, is_tail, any_sel;
  logic [VC_W-1:0]       sel_idx;

  assign is_alloc = fl_valid && (fl_type == FT_HEAD || fl_type == FT_SINGLE);
  assign is_look  = fl_valid && (fl_type == FT_BODY || fl_type == FT_TAIL);
  assign is_tail  = fl_valid && (fl_type == FT_TAIL);

  vcmap_alloc #(.NUM_VNET(NUM_VNET), .VC_PER_VNET(VC_PER_VNET)) u_alloc (
    .clk(clk), .rst_n(rst_n), .free_i(free_vec), .vnet_i(fl_vnet), .gnt_o(gnt)
  );

  vcmap_match #(.NUM_VNET(NUM_VNET), .VC_PER_VNET(VC_PER_VNET), .ID_W(ID_W)) u_match (
    .clk(clk), .rst_n(rst_n), .look_i(is_look), .bound_i(bound_vec),
    .src_tab_i(src_tab), .vnet_i(fl_vnet), .src_i(fl_src), .hit_o(match)
  );

  for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
    logic [ID_W-1:0] src_q;
    vcmap_entry #(.ID_W(ID_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (is_alloc && gnt[i]),
      .kind_i  (fl_type),
      .stop_i  (fl_stop),
      .tail_i  (is_tail && match[i]),
      .dep_i   (dep_valid && (dep_vc == VC_W'(i))),
      .src_i   (fl_src),
      .state_o (st[i]),
      .src_o   (src_q)
    );
    assign free_vec[i]  = (st[i] == VC_FREE);
    assign bound_vec[i] = (st[i] == VC_BOUND);
    assign drain_vec[i] = (st[i] == VC_DRAIN);
    assign src_tab[i*ID_W +: ID_W] = src_q;
  end

  for (genvar v = 0; v < NUM_VNET; v++) begin : g_avail
    assign vc_avail[v] = |free_vec[v*VC_PER_VNET +: VC_PER_VNET];
  end

  always_comb begin
    sel = '0;
    if (is_alloc)     sel = gnt;
    else if (is_look) sel = match;
    any_sel = |sel;
    sel_idx = '0;
    for (int i = 0; i < NUM_VC; i++)
      if (sel[i]) sel_idx = VC_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_vc    <= '0;
      err_miss  <= 1'b0;
      err_full  <= 1'b0;
    end else begin
      res_valid <= fl_valid;
      res_hit   <= any_sel;
      res_vc    <= sel_idx;
      err_miss  <= is_look && !any_sel;
      err_full  <= is_alloc && !any_sel;
    end
  end

  // a failed outcome never reports a VC (R4, R5)
  assert_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_miss || err_full) |-> (res_valid && !res_hit && !(err_miss && err_full)));

  // a release aimed at a non-held VC leaves the free set unchanged (R7)
  assert_dep_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_valid && !drain_vec[dep_vc] && !fl_valid) |=> $stable(free_vec));
endmodule

// File: tb/sim_vcmap_table.sv
module sim_vcmap_table;
  localparam int NV = 2, VP = 2, IDW = 6, NVC = NV * VP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fl_valid = 0, fl_stop = 0, dep_valid = 0;
  logic [1:0] fl_type = 0, dep_vc = 0;
  logic [0:0] fl_vnet = 0;
  logic [IDW-1:0] fl_src = 0;
  logic res_valid, res_hit, err_miss, err_full;
  logic [1:0] res_vc;
  logic [NV-1:0] vc_avail;

  always #5 clk = ~clk;

  vcmap_table #(.NUM_VNET(NV), .VC_PER_VNET(VP), .ID_W(IDW)) u0 (
    .clk(clk), .rst_n(rst_n), .fl_valid(fl_valid), .fl_type(fl_type),
    .fl_stop(fl_stop), .fl_vnet(fl_vnet), .fl_src(fl_src),
    .dep_valid(dep_valid), .dep_vc(dep_vc), .res_valid(res_valid),
    .res_hit(res_hit), .res_vc(res_vc), .err_miss(err_miss),
    .err_full(err_full), .vc_avail(vc_avail)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;
  int mst [NVC];   // 0 free, 1 bound, 2 held
  int mid [NVC];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, predict, check after the registering edge
  task automatic step(input bit v, input int t, input bit s, input int vn, input int id,
                      input bit dv, input int dvc, input string tag);
    int nst [NVC];
    bit e_hit = 0, e_miss = 0, e_full = 0;
    int e_vc = 0;
    for (int k = 0; k < NVC; k++) nst[k] = mst[k];
    if (v) begin
      if (t == 0 || t == 3) begin
        for (int k = vn*VP; k < vn*VP+VP; k++)
          if (!e_hit && mst[k] == 0) begin
            e_hit = 1; e_vc = k;
            if (t == 0) begin nst[k] = 1; mid[k] = id; end
            else nst[k] = s ? 2 : 0;
          end
        e_full = !e_hit;
      end else begin
        for (int k = vn*VP; k < vn*VP+VP; k++)
          if (mst[k] == 1 && mid[k] == id) begin
            e_hit = 1; e_vc = k;
            if (t == 2) nst[k] = s ? 2 : 0;
          end
        e_miss = !e_hit;
      end
    end
    if (dv && mst[dvc] == 2) nst[dvc] = 0;
    for (int k = 0; k < NVC; k++) mst[k] = nst[k];
    fl_valid = v; fl_type = 2'(t); fl_stop = s; fl_vnet = 1'(vn); fl_src = 6'(id);
    dep_valid = dv; dep_vc = 2'(dvc);
    @(negedge clk);
    chk(tag, "res_valid", int'(res_valid), int'(v));
    chk(tag, "res_hit", int'(res_hit), int'(e_hit));
    if (e_hit) chk(tag, "res_vc", int'(res_vc), e_vc);
    chk((t == 3) ? tag : "R4", "err_miss", int'(err_miss), int'(e_miss));
    chk((t == 3) ? tag : "R5", "err_full", int'(err_full), int'(e_full));
    for (int n = 0; n < NV; n++) begin
      bit f = 0;
      for (int k = n*VP; k < n*VP+VP; k++) if (mst[k] == 0) f = 1;
      chk("R10", "vc_avail", int'(vc_avail[n]), int'(f));
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    for (int k = 0; k < NVC; k++) begin mst[k] = 0; mid[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "vc_avail", int'(vc_avail), 3);
    chk("R1", "res_valid", int'(res_valid), 0);
    chk("R1", "errors", int'(err_miss | err_full), 0);
    idle("R1");
    step(1, 0, 1, 0, 5, 0, 0, "R2");   // vc0
    step(1, 0, 0, 0, 9, 0, 0, "R2");   // passing head, vc1
    step(1, 1, 1, 0, 5, 0, 0, "R3");
    step(1, 1, 0, 0, 9, 0, 0, "R3");
    step(1, 0, 1, 0, 7, 0, 0, "R5");   // network 0 full
    step(1, 1, 1, 0, 3, 0, 0, "R4");   // unknown ID
    step(1, 0, 1, 1, 5, 0, 0, "R11");  // same ID, other network -> vc2
    step(1, 1, 1, 1, 5, 0, 0, "R11");
    step(1, 2, 0, 0, 9, 0, 0, "R8");   // passing tail frees vc1
    step(1, 0, 1, 0, 11, 0, 0, "R8");  // reuses vc1
    step(1, 2, 1, 0, 5, 0, 0, "R6");   // vc0 held
    step(1, 1, 1, 0, 5, 0, 0, "R6");   // now misses
    step(1, 0, 1, 0, 12, 0, 0, "R6");  // still full
    step(1, 0, 1, 0, 13, 1, 0, "R7");  // release and head together: full
    step(1, 0, 1, 0, 13, 0, 0, "R7");  // vc0 now free
    step(0, 0, 0, 0, 0, 1, 1, "R7");   // release of bound vc1 ignored
    step(1, 1, 1, 0, 11, 0, 0, "R7");
    step(1, 3, 0, 1, 20, 0, 0, "R9");  // passing single -> vc3, none held
    step(1, 3, 1, 1, 21, 0, 0, "R9");  // stopping single -> vc3 held
    step(1, 3, 1, 1, 22, 0, 0, "R9");  // network 1 full
    step(0, 0, 0, 0, 0, 1, 3, "R9");
    idle("R10");
    for (int i = 0; i < 400; i++) begin
      int r, t, vn, id;
      bit s, dv;
      seed = seed * 1103515245 + 12345;
      r  = (seed >>> 8) & 32'h7fff_ffff;
      t  = r % 4; s = r[3]; vn = (r >> 4) % 2; id = (r >> 5) % 6;
      dv = r[9]; 
      if (t == 0)
        for (int k = vn*VP; k < vn*VP+VP; k++) if (mst[k] == 1 && mid[k] == id) t = 1;
      step(r[10] | r[11], t, s, vn, id, dv, (r >> 12) % NVC, "R3");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule